// File: doc/BRIEF.md
# Accumulator ALU with Flag Logic

This block is the arithmetic and logic core behind the accumulator of a small single-chip controller. On every clock it takes an operation code, the present accumulator value, one operand byte (already picked by the surrounding datapath from a working register, internal RAM or an immediate field) and the present carry (C) and auxiliary-carry (AC) flags. One cycle later it presents the new accumulator value, the new flags and a write-back byte that the surrounding datapath stores back to the operand's location.

The operation set covers addition with and without incoming carry, bitwise AND/OR/XOR, complement and clear of the accumulator, increment and decrement, four rotates, nibble swap, BCD decimal adjust, full and low-nibble exchange with the operand, a 4-bit expander-port read, and clear or complement of the carry alone. Codes with no operation assigned leave the state untouched. Fetch, operand addressing, register banks and port pins belong to other blocks.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the following outputs are `acc_o`=0, `c_o`=0, `ac_o`=0, `wb_o`=0.
- R2: ADD (code 0) gives `acc_o`=(acc+opnd) mod 256; ADDC (code 1) also adds `c_i`. For both, `c_o` is the carry out of bit 7 and `ac_o` the carry out of bit 3.
- R3: AND (2), OR (3), XOR (4) combine acc with opnd; CPLA (5) gives the one's complement of acc; CLRA (6) gives 0; INCA (7) gives acc+1 and DECA (8) acc-1, both modulo 256. None of these changes C or AC.
- R4: RL (9) and RR (11) rotate acc by one place left or right and keep C. RLC (10) and RRC (12) rotate the 9-bit value formed by C and acc, so the bit shifted out of acc lands in C and the old C enters at the other end. AC is kept.
- R5: SWAP (13) exchanges acc bits 3:0 with bits 7:4; flags kept.
- R6: DAA (14) adds 6 when acc bits 3:0 exceed 9 or AC is 1; it then adds 0x60 and sets C when the bits 7:4 of that sum exceed 9, C is 1 or the first step carried out of bit 7. C is never cleared by it and AC is kept.
- R7: XCH (15) returns opnd as `acc_o` and acc as `wb_o`. XCHD (16) swaps only bits 3:0 of acc and opnd: `acc_o`={acc[7:4],opnd[3:0]}, `wb_o`={opnd[7:4],acc[3:0]}. Flags kept.
- R8: PORTRD (17) gives `acc_o`={4'b0000, opnd[3:0]}; flags kept.
- R9: CLRC (18) clears C and CPLC (19) inverts C; acc and AC are kept.
- R10: Codes 20 to 31 leave acc, C and AC unchanged.
- R11: For every code other than 15 and 16, `wb_o` equals the operand.
- R12: Every output is registered: the values after rising edge k reflect the inputs sampled at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code (values in R2 to R10) |
| acc_i | input | DATA_W | Present accumulator value |
| opnd_i | input | DATA_W | Operand byte from register, RAM or immediate |
| c_i | input | 1 | Present carry flag |
| ac_i | input | 1 | Present auxiliary-carry flag |
| acc_o | output | DATA_W | New accumulator value |
| c_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary-carry flag |
| wb_o | output | DATA_W | Byte to store back to the operand location |

## Verification
The bench builds the block with its default `DATA_W` of 8, the only width at which the nibble flags and the decimal adjust carry their BCD meaning. At that width every code, including one unassigned code, can be driven with all 256 accumulator values and all four C/AC combinations, so every carry boundary, every DAA correction path and every rotate end bit is reached. Operands are varied with the accumulator so binary operations see a spread of pairs, and a few hand-worked decimal-adjust cases are added.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        ALU_ADD    = 5'd0,
        ALU_ADDC   = 5'd1,
        ALU_AND    = 5'd2,
        ALU_OR     = 5'd3,
        ALU_XOR    = 5'd4,
        ALU_CPLA   = 5'd5,
        ALU_CLRA   = 5'd6,
        ALU_INCA   = 5'd7,
        ALU_DECA   = 5'd8,
        ALU_RL     = 5'd9,
        ALU_RLC    = 5'd10,
        ALU_RR     = 5'd11,
        ALU_RRC    = 5'd12,
        ALU_SWAP   = 5'd13,
        ALU_DAA    = 5'd14,
        ALU_XCH    = 5'd15,
        ALU_XCHD   = 5'd16,
        ALU_PORTRD = 5'd17,
        ALU_CLRC   = 5'd18,
        ALU_CPLC   = 5'd19
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic aux;
    } alu_flags_t;

    function automatic logic is_exchange(input alu_op_e op);
        return (op == ALU_XCH) || (op == ALU_XCHD);
    endfunction

    function automatic logic keeps_flags(input alu_op_e op);
        return (op == ALU_AND) || (op == ALU_OR) || (op == ALU_XOR) ||
               (op == ALU_CPLA) || (op == ALU_CLRA) ||
               (op == ALU_INCA) || (op == ALU_DECA);
    endfunction

    function automatic logic uses_adder(input alu_op_e op);
        return (op == ALU_ADD) || (op == ALU_ADDC) ||
               (op == ALU_INCA) || (op == ALU_DECA);
    endfunction

endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          aux
);
    localparam int NW = DW / 2;
    localparam int HW = DW - NW;

    logic [NW:0] lo_sum;
    logic [HW:0] hi_sum;

    always_comb begin
        lo_sum = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        hi_sum = {1'b0, a[DW-1:NW]} + {1'b0, b[DW-1:NW]} + {{HW{1'b0}}, lo_sum[NW]};
        sum    = {hi_sum[HW-1:0], lo_sum[NW-1:0]};
        cout   = hi_sum[HW];
        aux    = lo_sum[NW];
    end

endmodule

// File: rtl/acc_bitops.sv
module acc_bitops
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c_in,
    output logic          hit,
    output logic [DW-1:0] res,
    output logic          c_out
);
    localparam int NW = DW / 2;

    always_comb begin
        hit   = 1'b1;
        res   = a;
        c_out = c_in;
        case (op)
            ALU_AND:    res = a & b;
            ALU_OR:     res = a | b;
            ALU_XOR:    res = a ^ b;
            ALU_CPLA:   res = ~a;
            ALU_CLRA:   res = '0;
            ALU_RL:     res = {a[DW-2:0], a[DW-1]};
            ALU_RR:     res = {a[0], a[DW-1:1]};
            ALU_RLC: begin
                res   = {a[DW-2:0], c_in};
                c_out = a[DW-1];
            end
            ALU_RRC: begin
                res   = {c_in, a[DW-1:1]};
                c_out = a[0];
            end
            ALU_SWAP:   res = {a[NW-1:0], a[DW-1:NW]};
            ALU_PORTRD: res = {{(DW-NW){1'b0}}, b[NW-1:0]};
            ALU_CLRC:   c_out = 1'b0;
            ALU_CPLC:   c_out = ~c_in;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_decadj.sv
module acc_decadj #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic          c_in,
    input  logic          ac_in,
    output logic [DW-1:0] res,
    output logic          c_out
);
    localparam int NW = DW / 2;

    logic [DW-1:0] lo_corr;
    logic [DW-1:0] hi_corr;
    logic          lo_fix;
    logic          hi_fix;
    logic [DW:0]   step1;

    assign lo_corr = DW'(6);
    assign hi_corr = DW'(6) << NW;

    always_comb begin
        lo_fix = (a[NW-1:0] > NW'(9)) || ac_in;
        step1  = {1'b0, a} + {1'b0, (lo_fix ? lo_corr : '0)};
        hi_fix = (step1[DW-1:NW] > (DW-NW)'(9)) || c_in || step1[DW];
        res    = step1[DW-1:0] + (hi_fix ? hi_corr : '0);
        c_out  = hi_fix;
    end

    // R6: the adjust may set carry but never clears it
    always_comb begin
        if (c_in === 1'b1) begin
            assert_daa_keeps_carry_R6: assert (c_out === 1'b1);
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              c_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] acc_o,
    output logic              c_o,
    output logic              ac_o,
    output logic [DATA_W-1:0] wb_o
);
    localparam int NW = DATA_W / 2;

    alu_op_e       op;
    logic [DATA_W-1:0] add_b;
    logic          add_cin;
    logic [DATA_W-1:0] add_sum;
    logic          add_cout;
    logic          add_aux;
    logic          bl_hit;
    logic [DATA_W-1:0] bl_res;
    logic          bl_c;
    logic [DATA_W-1:0] da_res;
    logic          da_c;

    logic [DATA_W-1:0] nxt_acc;
    logic [DATA_W-1:0] nxt_wb;
    alu_flags_t    nxt_flg;

    assign op = alu_op_e'(op_i);

    // one shared adder serves add, add-with-carry, increment and decrement
    always_comb begin
        add_b   = opnd_i;
        add_cin = 1'b0;
        case (op)
            ALU_ADDC: add_cin = c_i;
            ALU_INCA: begin
                add_b   = '0;
                add_cin = 1'b1;
            end
            ALU_DECA: add_b = '1;
            default: ;
        endcase
    end

    acc_adder #(.DW(DATA_W)) u_adder (
        .a    (acc_i),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .aux  (add_aux)
    );

    acc_bitops #(.DW(DATA_W)) u_bitops (
        .op    (op),
        .a     (acc_i),
        .b     (opnd_i),
        .c_in  (c_i),
        .hit   (bl_hit),
        .res   (bl_res),
        .c_out (bl_c)
    );

    acc_decadj #(.DW(DATA_W)) u_decadj (
        .a     (acc_i),
        .c_in  (c_i),
        .ac_in (ac_i),
        .res   (da_res),
        .c_out (da_c)
    );

    always_comb begin
        nxt_acc = acc_i;
        nxt_wb  = opnd_i;
        nxt_flg = '{carry: c_i, aux: ac_i};
        case (op)
            ALU_ADD, ALU_ADDC: begin
                nxt_acc = add_sum;
                nxt_flg = '{carry: add_cout, aux: add_aux};
            end
            ALU_INCA, ALU_DECA: nxt_acc = add_sum;
            ALU_DAA: begin
                nxt_acc       = da_res;
                nxt_flg.carry = da_c;
            end
            ALU_XCH: begin
                nxt_acc = opnd_i;
                nxt_wb  = acc_i;
            end
            ALU_XCHD: begin
                nxt_acc = {acc_i[DATA_W-1:NW], opnd_i[NW-1:0]};
                nxt_wb  = {opnd_i[DATA_W-1:NW], acc_i[NW-1:0]};
            end
            default: begin
                if (bl_hit) begin
                    nxt_acc       = bl_res;
                    nxt_flg.carry = bl_c;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= '0;
            c_o   <= 1'b0;
            ac_o  <= 1'b0;
            wb_o  <= '0;
        end else begin
            acc_o <= nxt_acc;
            c_o   <= nxt_flg.carry;
            ac_o  <= nxt_flg.aux;
            wb_o  <= nxt_wb;
        end
    end

    // ---------------- assertions ----------------
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && !c_o && !ac_o && wb_o == '0));

    assert_flags_kept_R3: assert property (@(posedge clk) disable iff (rst)
        keeps_flags(op) |=> (c_o == $past(c_i) && ac_o == $past(ac_i)));

    assert_clear_gives_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (op == ALU_CLRA) |=> (acc_o == '0));

    assert_plain_rotate_keeps_c_R4: assert property (@(posedge clk) disable iff (rst)
        (op == ALU_RL || op == ALU_RR) |=> (c_o == $past(c_i)));

    assert_port_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (op == ALU_PORTRD) |=> (acc_o[DATA_W-1:NW] == '0));

    assert_wb_passthrough_R11: assert property (@(posedge clk) disable iff (rst)
        !is_exchange(op) |=> (wb_o == $past(opnd_i)));

    assert_unassigned_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_W'(19)) |=> (acc_o == $past(acc_i) && c_o == $past(c_i) &&
                                ac_o == $past(ac_i)));

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
    import acc_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic       c_i = 1'b0;
    logic       ac_i = 1'b0;
    logic [7:0] acc_o;
    logic       c_o;
    logic       ac_o;
    logic [7:0] wb_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int op;
        int ra;
        int rc;
        int rac;
        int rw;
    } exp_t;

    exp_t pend[$];

    always #2.5 clk = ~clk;

    acc_alu #(.DATA_W(8)) uut (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op_i),
        .acc_i  (acc_i),
        .opnd_i (opnd_i),
        .c_i    (c_i),
        .ac_i   (ac_i),
        .acc_o  (acc_o),
        .c_o    (c_o),
        .ac_o   (ac_o),
        .wb_o   (wb_o)
    );

    function automatic string tag_of(input int op);
        if (op <= 1) return "R2";
        if (op <= 8) return "R3";
        if (op <= 12) return "R4";
        if (op == 13) return "R5";
        if (op == 14) return "R6";
        if (op <= 16) return "R7";
        if (op == 17) return "R8";
        if (op <= 19) return "R9";
        return "R10";
    endfunction

    // behavioural reference written from the requirements
    function automatic exp_t model(input int op, input int a, input int b,
                                   input int c, input int ac);
        exp_t e;
        int t;
        e.op = op; e.ra = a; e.rc = c; e.rac = ac; e.rw = b;
        case (op)
            0: begin
                t = a + b;
                e.ra = t % 256; e.rc = (t > 255) ? 1 : 0;
                e.rac = ((a % 16) + (b % 16) > 15) ? 1 : 0;
            end
            1: begin
                t = a + b + c;
                e.ra = t % 256; e.rc = (t > 255) ? 1 : 0;
                e.rac = ((a % 16) + (b % 16) + c > 15) ? 1 : 0;
            end
            2: e.ra = a & b;
            3: e.ra = a | b;
            4: e.ra = a ^ b;
            5: e.ra = 255 - a;
            6: e.ra = 0;
            7: e.ra = (a + 1) % 256;
            8: e.ra = (a + 255) % 256;
            9:  e.ra = ((a * 2) % 256) + (a / 128);
            10: begin e.ra = ((a * 2) % 256) + c; e.rc = a / 128; end
            11: e.ra = (a / 2) + ((a % 2) * 128);
            12: begin e.ra = (a / 2) + c * 128; e.rc = a % 2; end
            13: e.ra = (a % 16) * 16 + (a / 16);
            14: begin
                t = a;
                if ((t % 16) > 9 || ac == 1) t = t + 6;
                if (((t / 16) % 16) > 9 || c == 1 || t > 255) begin
                    t = t + 96;
                    e.rc = 1;
                end
                e.ra = t % 256;
            end
            15: begin e.ra = b; e.rw = a; end
            16: begin
                e.ra = (a / 16) * 16 + (b % 16);
                e.rw = (b / 16) * 16 + (a % 16);
            end
            17: e.ra = b % 16;
            18: e.rc = 0;
            19: e.rc = 1 - c;
            default: ;
        endcase
        return e;
    endfunction

    task automatic compare_front();
        exp_t e;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        checks++;
        if (int'(acc_o) != e.ra || int'(c_o) != e.rc || int'(ac_o) != e.rac ||
            int'(wb_o) != e.rw) begin
            errors++;
            $display("FAIL %s (R12 timing) op=%0d: acc/c/ac/wb got %02h/%0d/%0d/%02h expected %02h/%0d/%0d/%02h",
                     tag_of(e.op), e.op, acc_o, c_o, ac_o, wb_o, e.ra, e.rc, e.rac, e.rw);
        end
    endtask

    // called at a falling edge: checks the previous vector, drives the next
    task automatic step(input int op, input int a, input int b, input int c, input int ac);
        compare_front();
        op_i   = 5'(op);
        acc_i  = 8'(a);
        opnd_i = 8'(b);
        c_i    = c[0];
        ac_i   = ac[0];
        pend.push_back(model(op, a, b, c, ac));
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        // R1: reset with busy inputs
        op_i = 5'd0; acc_i = 8'hA5; opnd_i = 8'h7E; c_i = 1'b1; ac_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (acc_o != 8'h00 || c_o != 1'b0 || ac_o != 1'b0 || wb_o != 8'h00) begin
            errors++;
            $display("FAIL R1 reset: got %02h/%0d/%0d/%02h expected 00/0/0/00",
                     acc_o, c_o, ac_o, wb_o);
        end
        rst = 1'b0;

        // directed decimal-adjust cases (R6)
        step(14, 8'h3C, 0, 0, 0);   // -> 42, C=0
        step(14, 8'h9A, 0, 0, 0);   // -> 00, C=1
        step(14, 8'h08, 0, 0, 1);   // -> 0E, C=0
        step(14, 8'h12, 0, 1, 0);   // -> 72, C=1
        step(14, 8'hFF, 0, 0, 0);   // first step carries -> 65, C=1

        // directed add boundaries (R2)
        step(0, 8'h0F, 8'h01, 0, 0);
        step(1, 8'hFF, 8'h00, 1, 0);

        // full sweep: every code plus one unassigned (R2..R11, R12)
        for (int op = 0; op <= 20; op++) begin
            for (int v = 0; v < 256; v++) begin
                for (int f = 0; f < 4; f++) begin
                    int opv;
                    opv = (op == 20) ? 31 : op;
                    step(opv, v, (v * 37 + 91 + f * 13) % 256, f / 2, f % 2);
                end
            end
        end
        compare_front();
        done = 1;
        finish_run();
    end

endmodule